// File: doc/BRIEF.md
# Gate-Level AES Byte Substitution Pipeline

This block substitutes one byte per clock with either the AES forward S-box or its inverse. No lookup table is used. The byte is carried into a tower field: GF(2^8) is built as a quadratic extension of GF(2^4), which is built over GF(2^2). The multiplicative inverse is taken there and the result is carried back. In forward mode the affine step follows the inversion. In inverse mode the inverse affine step comes before it.

The field-change matrices are derived at elaboration time. A constant function searches the tower field for a root of the AES reduction polynomial and takes its powers as the matrix columns, so no hand-entered bit matrix exists. Two internal registers and an output register split the datapath into three substages:

1. Mapping and the norm computation.
2. Inversion in GF(2^4).
3. The closing multiply, the mapping back and the affine step.

A new byte may enter on every clock, and each byte may choose its own mode.

Top module: `cf_sbox_pipe`

## Requirements
- R1: While reset is asserted, and on the first sampling after it, `out_valid` is 0.
- R2: With `in_inverse` = 0 (forward mode), `out_byte` equals the AES forward S-box of `in_byte` for all 256 input values; for example 0x53 gives 0xED.
- R3: With `in_inverse` = 1 (inverse mode), `out_byte` equals the AES inverse S-box of `in_byte` for all 256 input values; for example 0xED gives 0x53.
- R4: The inverse of zero is defined as zero. Forward 0x00 gives 0x63, inverse 0x63 gives 0x00, and a zero tower-field element yields a zero norm and a zero inverse.
- R5: A byte accepted on a clock edge with `in_valid` = 1 appears on `out_byte` with `out_valid` = 1 exactly three edges later. A cycle with `in_valid` = 0 gives `out_valid` = 0 three edges later.
- R6: Bytes may be accepted on consecutive cycles with the mode changing from byte to byte, and each result depends only on its own byte and mode.
- R7: For every nonzero tower-field element, the norm is nonzero, the norm times its GF(2^4) inverse is one, and the element times its computed inverse is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is present this cycle |
| in_inverse | input | 1 | 0 selects forward substitution, 1 selects inverse |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Result byte is present this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
Two back-to-back sweeps over all 256 values, one per mode, separate a wrong isomorphism matrix or a wrong field constant, which corrupts most entries, from a wrong affine constant or a swapped affine order, which corrupts every entry of only one mode. Spot bytes at zero and 0x53/0xED isolate the zero-inverse path from the general inversion. A pseudo-random run with mixed modes and idle gaps exposes mode or valid bits that drift out of step with their data, which a sweep in one mode cannot reveal.

// File: rtl/aes_cf_pkg.sv
package aes_cf_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int PAIR_W = NIB_W / 2;
  localparam int MAT_W  = BYTE_W * BYTE_W;

  localparam logic [PAIR_W-1:0] PHI    = 2'b10;
  localparam logic [NIB_W-1:0]  LAMBDA = 4'b1100;
  localparam logic [BYTE_W-1:0] AFF_C  = 8'h63;
  localparam logic [BYTE_W-1:0] IAFF_C = 8'h05;

  // GF(2^2), modulus x^2 + x + 1
  function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
    logic t;
    t = a[1] & b[1];
    return {t ^ (a[1] & b[0]) ^ (a[0] & b[1]), t ^ (a[0] & b[0])};
  endfunction

  // in GF(2^2) the inverse of a nonzero element is its square
  function automatic logic [1:0] gf4_inv(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // GF(2^4) over GF(2^2), modulus y^2 + y + PHI
  function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh;
    hh = gf4_mul(a[3:2], b[3:2]);
    return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
            gf4_mul(hh, PHI) ^ gf4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [3:0] gf16_inv(input logic [3:0] a);
    logic [1:0] nrm, ninv;
    nrm  = gf4_mul(PHI, gf4_mul(a[3:2], a[3:2])) ^ gf4_mul(a[3:2], a[1:0])
         ^ gf4_mul(a[1:0], a[1:0]);
    ninv = gf4_inv(nrm);
    return {gf4_mul(a[3:2], ninv), gf4_mul(a[3:2] ^ a[1:0], ninv)};
  endfunction

  // GF(2^8) over GF(2^4), modulus z^2 + z + LAMBDA
  function automatic logic [7:0] gf256c_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = gf16_mul(a[7:4], b[7:4]);
    return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
            gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [3:0] cf_norm(input logic [7:0] a);
    return gf16_mul(LAMBDA, gf16_mul(a[7:4], a[7:4])) ^ gf16_mul(a[7:4], a[3:0])
         ^ gf16_mul(a[3:0], a[3:0]);
  endfunction

  // column i of the matrix sits at bits [8i +: 8]
  function automatic logic [7:0] cf_apply(input logic [MAT_W-1:0] m, input logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (v[i]) r = r ^ m[BYTE_W*i +: BYTE_W];
    return r;
  endfunction

  // first tower element that is a root of x^8 + x^4 + x^3 + x + 1
  function automatic logic [7:0] cf_root();
    logic [7:0] r, r2, r3, r4, r8, root;
    logic found;
    root  = 8'h01;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      r  = 8'(c);
      r2 = gf256c_mul(r, r);
      r3 = gf256c_mul(r2, r);
      r4 = gf256c_mul(r2, r2);
      r8 = gf256c_mul(r4, r4);
      if (!found && ((r8 ^ r4 ^ r3 ^ r ^ 8'h01) == 8'h00)) begin
        root  = r;
        found = 1'b1;
      end
    end
    return root;
  endfunction

  function automatic logic [MAT_W-1:0] cf_to_tower();
    logic [MAT_W-1:0] m;
    logic [7:0] p, root;
    root = cf_root();
    p    = 8'h01;
    m    = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      m[BYTE_W*i +: BYTE_W] = p;
      p = gf256c_mul(p, root);
    end
    return m;
  endfunction

  function automatic logic [MAT_W-1:0] cf_from_tower();
    logic [MAT_W-1:0] fwd, m;
    logic [7:0] unit;
    fwd = cf_to_tower();
    m   = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      unit = 8'h01 << j;
      for (int c = 0; c < 256; c++)
        if (cf_apply(fwd, 8'(c)) == unit) m[BYTE_W*j +: BYTE_W] = 8'(c);
    end
    return m;
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] a);
    logic [7:0] r;
    for (int i = 0; i < BYTE_W; i++)
      r[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ AFF_C[i];
    return r;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] a);
    logic [7:0] r;
    for (int i = 0; i < BYTE_W; i++)
      r[i] = a[(i+2)%8] ^ a[(i+5)%8] ^ a[(i+7)%8] ^ IAFF_C[i];
    return r;
  endfunction
endpackage

// File: rtl/cf_map_stage.sv
module cf_map_stage
  import aes_cf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              inv_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              vld_o,
  output logic              inv_o,
  output logic [BYTE_W-1:0] elem_o,
  output logic [NIB_W-1:0]  norm_o
);
  localparam logic [MAT_W-1:0] TO_CF = cf_to_tower();

  logic [BYTE_W-1:0] pre_aff;
  logic [BYTE_W-1:0] tower_elem;
  logic [NIB_W-1:0]  elem_norm;

  always_comb begin
    pre_aff    = inv_i ? aff_inv(byte_i) : byte_i;
    tower_elem = cf_apply(TO_CF, pre_aff);
    elem_norm  = cf_norm(tower_elem);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      inv_o  <= 1'b0;
      elem_o <= '0;
      norm_o <= '0;
    end else begin
      vld_o  <= vld_i;
      inv_o  <= inv_i;
      elem_o <= tower_elem;
      norm_o <= elem_norm;
    end
  end

  AST_MAP_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_aff == 8'h00) == (tower_elem == 8'h00)); // R4
  AST_NORM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tower_elem != 8'h00) |-> (elem_norm != 4'h0)); // R7
endmodule

// File: rtl/cf_inv16_stage.sv
module cf_inv16_stage
  import aes_cf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              inv_i,
  input  logic [BYTE_W-1:0] elem_i,
  input  logic [NIB_W-1:0]  norm_i,
  output logic              vld_o,
  output logic              inv_o,
  output logic [BYTE_W-1:0] elem_o,
  output logic [NIB_W-1:0]  ninv_o
);
  logic [NIB_W-1:0] norm_inv;

  always_comb norm_inv = gf16_inv(norm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      inv_o  <= 1'b0;
      elem_o <= '0;
      ninv_o <= '0;
    end else begin
      vld_o  <= vld_i;
      inv_o  <= inv_i;
      elem_o <= elem_i;
      ninv_o <= norm_inv;
    end
  end

  AST_NORM_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_i != 4'h0) |=> (gf16_mul(ninv_o, $past(norm_i)) == 4'h1)); // R7
  AST_ZERO_NORM_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_i == 4'h0) |=> (ninv_o == 4'h0)); // R4
endmodule

// File: rtl/cf_out_stage.sv
module cf_out_stage
  import aes_cf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              inv_i,
  input  logic [BYTE_W-1:0] elem_i,
  input  logic [NIB_W-1:0]  ninv_i,
  output logic              vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [MAT_W-1:0] FROM_CF = cf_from_tower();

  logic [BYTE_W-1:0] tower_inv;
  logic [BYTE_W-1:0] mapped_back;
  logic [BYTE_W-1:0] result;

  always_comb begin
    tower_inv   = {gf16_mul(elem_i[7:4], ninv_i), gf16_mul(elem_i[7:4] ^ elem_i[3:0], ninv_i)};
    mapped_back = cf_apply(FROM_CF, tower_inv);
    result      = inv_i ? mapped_back : aff_fwd(mapped_back);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      vld_o  <= vld_i;
      byte_o <= result;
    end
  end

  AST_FULL_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_i != 8'h00) |-> (gf256c_mul(elem_i, tower_inv) == 8'h01)); // R7
  AST_ZERO_ELEM_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_i == 8'h00) |-> (tower_inv == 8'h00)); // R4
endmodule

// File: rtl/cf_sbox_pipe.sv
module cf_sbox_pipe
  import aes_cf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_inverse,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);
  logic              vld_s1, inv_s1, vld_s2, inv_s2;
  logic [BYTE_W-1:0] elem_s1, elem_s2;
  logic [NIB_W-1:0]  norm_s1, ninv_s2;

  cf_map_stage u_map (
    .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .inv_i(in_inverse), .byte_i(in_byte),
    .vld_o(vld_s1), .inv_o(inv_s1), .elem_o(elem_s1), .norm_o(norm_s1)
  );

  cf_inv16_stage u_inv (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_s1), .inv_i(inv_s1), .elem_i(elem_s1),
    .norm_i(norm_s1), .vld_o(vld_s2), .inv_o(inv_s2), .elem_o(elem_s2), .ninv_o(ninv_s2)
  );

  cf_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_s2), .inv_i(inv_s2), .elem_i(elem_s2),
    .ninv_i(ninv_s2), .vld_o(out_valid), .byte_o(out_byte)
  );

  AST_VALID_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    vld_s2 |=> out_valid); // R5
  AST_BUBBLE_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_s2 |=> !out_valid); // R5
  AST_ENTRY_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> vld_s1); // R5
endmodule

// File: tb/sim_cf_sbox_pipe.sv
module sim_cf_sbox_pipe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_inverse = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] fwd_tab [256];
  logic [7:0] inv_tab [256];

  logic       exp_v   [3];
  logic [7:0] exp_d   [3];
  string      exp_tag [3];

  always #4 clk = ~clk;

  cf_sbox_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inverse(in_inverse),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte)
  );

  function automatic logic [7:0] aes_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_ref();
    logic [7:0] inv;
    for (int a = 0; a < 256; a++) begin
      inv = 8'h00;
      for (int b = 1; b < 256; b++)
        if (aes_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      fwd_tab[a] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    end
    for (int a = 0; a < 256; a++) inv_tab[fwd_tab[a]] = 8'(a);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // one clock: compare outputs with the model, advance the model, drive new inputs
  task automatic step(input logic v, input logic m, input logic [7:0] b, input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== exp_v[2]) begin
      failures++;
      $display("FAIL R5 out_valid actual=%b expected=%b", out_valid, exp_v[2]);
    end
    if (exp_v[2]) begin
      checks++;
      if (out_byte !== exp_d[2]) begin
        failures++;
        $display("FAIL %s out_byte actual=%02h expected=%02h", exp_tag[2], out_byte, exp_d[2]);
      end
    end
    for (int k = 2; k > 0; k--) begin
      exp_v[k]   = exp_v[k-1];
      exp_d[k]   = exp_d[k-1];
      exp_tag[k] = exp_tag[k-1];
    end
    exp_v[0]   = v;
    exp_d[0]   = m ? inv_tab[b] : fwd_tab[b];
    exp_tag[0] = (tag != "") ? tag : (m ? "R3" : "R2");
    in_valid   = v;
    in_inverse = m;
    in_byte    = b;
  endtask

  initial begin
    logic [15:0] lf;
    build_ref();
    for (int k = 0; k < 3; k++) begin
      exp_v[k] = 1'b0; exp_d[k] = 8'h00; exp_tag[k] = "R5";
    end
    repeat (3) @(negedge clk);
    checks++;  // R1: held in reset
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 out_valid in reset actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1: first sample after release
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 out_valid after reset actual=%b expected=0", out_valid);
    end

    // R4: zero corners and known pair
    step(1'b1, 1'b0, 8'h00, "R4");
    step(1'b1, 1'b1, 8'h63, "R4");
    step(1'b1, 1'b0, 8'h53, "R4");
    step(1'b1, 1'b1, 8'hED, "R4");
    step(1'b0, 1'b0, 8'h00, "R5");
    // R2: full forward sweep, back to back
    for (int a = 0; a < 256; a++) step(1'b1, 1'b0, 8'(a), "R2");
    // R3: full inverse sweep
    for (int a = 255; a >= 0; a--) step(1'b1, 1'b1, 8'(a), "R3");
    // R6: mixed modes with bubbles
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0] != 4'h0, lf[9], lf[15:8] ^ lf[7:0], "R6");
    end
    for (int n = 0; n < 4; n++) step(1'b0, 1'b0, 8'h00, "R5");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule